// File: doc/BRIEF.md
# Double-Buffered IN Endpoint FIFO

This block is the transmit buffer of one IN endpoint in a USB function. It holds two banks of 64 bytes each. A DMA engine fills the bank that is open for writing, one byte per strobe. The USB serializer drains committed banks one packet at a time. It reads bytes through a port with one cycle of latency and releases each bank with a done pulse once the packet has been sent.

A bank becomes a packet in one of two ways:
- **Automatic commit.** When the 64th byte lands in a bank, that bank is committed and writing moves to the other bank. A message whose length is a multiple of 64 therefore needs no software action.
- **Software commit.** A shorter final packet is committed only by the software packet-enable strobe, typically issued from the DMA end interrupt.

While the enable input is set, the DMA request stays high whenever a bank is open. This holds even when the application has nothing more to send, so software ends a transfer by clearing the enable.

Top module: `inep_dbuf_fifo`

## Requirements
- R1: Each bank stores up to 64 bytes (`BANK_BYTES`). The bytes of a packet reach `rd_data` in the order they were written.
- R2: A write accepted while the open bank holds 63 bytes commits that bank in the same clock edge. Later writes go to the other bank.
- R3: A `pkt_commit` strobe while the open bank holds 1 to 63 bytes commits that bank. The resulting packet's `pkt_len` equals that byte count.
- R4: A `pkt_commit` strobe while the open bank is empty commits a zero-length packet, provided the previous commit was not automatic or a byte has been written since it.
- R5: A `pkt_commit` strobe is a no-op in two cases. The first is when both banks are committed. The second is when it directly follows an automatic commit with no byte written in between. In neither case is a second packet created.
- R6: `dma_req` is a register. After each clock edge it equals `dma_en` (as sampled at that edge) AND "at least one bank is not committed".
- R7: With `dma_en` low at a clock edge, `dma_req` is low after that edge.
- R8: Packets are presented in commit order. While `pkt_ready` is 1, `pkt_len` gives the byte count of the bank being drained. A `pkt_done` pulse while `pkt_ready` is 1 frees that bank and presents the next one.
- R9: Write strobes while both banks are committed are ignored. The committed packets keep their length and contents.
- R10: Synchronous active-high `rst` empties both banks and clears all commit state. After reset `dma_req` = 0, `pkt_ready` = 0 and `pkt_len` = 0.
- R11: A clock edge with `rd_stb` = 1 and `pkt_ready` = 1 places the byte at the current read position on `rd_data` and advances the position. The position returns to byte 0 on each freed bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | DMA enable for this endpoint |
| dma_req | output | 1 | DMA request, high while enabled and a bank is open |
| wr_stb | input | 1 | Write strobe from DMA |
| wr_data | input | DATA_W | Byte written with `wr_stb` |
| pkt_commit | input | 1 | Software packet-enable strobe |
| pkt_ready | output | 1 | A committed packet is available to the serializer |
| pkt_len | output | CNT_W | Byte count of the presented packet |
| rd_stb | input | 1 | Serializer byte read strobe |
| rd_data | output | DATA_W | Byte read, valid the cycle after `rd_stb` |
| pkt_done | input | 1 | Serializer finished sending the presented packet |

## Verification
The 150-byte message is sent in directed form and must drain as 64, 64 and 22. This separates the automatic commits from the software commit. An exact 64-byte transfer followed by a stray packet-enable shows whether a duplicate packet is created. A commit straight after reset shows that a zero-length packet is produced when it should be. Writes and commit strobes are also issued while both banks are held, and `dma_en` is toggled. These cases expose request and overwrite errors. A long random mix of writes, commits, drains and enable changes is compared every cycle against a packet-queue model, and this catches ordering, length and data faults that the directed cases miss.

// File: rtl/inep_pkg.sv
package inep_pkg;
  localparam int unsigned NUM_BANKS = 2;

  typedef logic bank_idx_t;

  function automatic bank_idx_t bank_flip(input bank_idx_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/inep_buf_ram.sv
module inep_buf_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/inep_bank_state.sv
module inep_bank_state #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_acc_i,
  input  logic             commit_i,
  input  logic             release_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             com_o
);
  always_ff @(posedge clk) begin
    if (rst || release_i) begin
      cnt_o <= '0;
      com_o <= 1'b0;
    end else begin
      if (wr_acc_i) cnt_o <= cnt_o + CNT_W'(1);
      if (commit_i) com_o <= 1'b1;
    end
  end
endmodule

// File: rtl/inep_dbuf_fifo.sv
module inep_dbuf_fifo #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANK_BYTES = 64,
  parameter int unsigned CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_en,
  output logic              dma_req,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pkt_commit,
  output logic              pkt_ready,
  output logic [CNT_W-1:0]  pkt_len,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pkt_done
);
  import inep_pkg::*;

  localparam int unsigned IDX_W  = $clog2(BANK_BYTES);
  localparam int unsigned ADDR_W = IDX_W + 1;

  bank_idx_t                          wr_bank, rd_bank;
  logic [IDX_W-1:0]                   rd_ptr;
  logic                               auto_arm;
  logic [NUM_BANKS-1:0][CNT_W-1:0]    bank_cnt;
  logic [NUM_BANKS-1:0]               bank_com;
  logic [NUM_BANKS-1:0]               bank_wr, bank_commit, bank_rel, com_next;

  logic [CNT_W-1:0] cur_cnt;
  logic             cur_com, wr_acc, fill_hit, sw_ok, do_commit, done_acc;

  assign cur_cnt  = bank_cnt[wr_bank];
  assign cur_com  = bank_com[wr_bank];
  assign wr_acc   = wr_stb && !cur_com;
  assign fill_hit = wr_acc && (cur_cnt == CNT_W'(BANK_BYTES - 1));
  // Software commit is dropped on a held bank, or right after an automatic
  // commit when nothing has been written since.
  assign sw_ok    = pkt_commit && !cur_com &&
                    !((cur_cnt == '0) && !wr_acc && auto_arm);
  assign do_commit = fill_hit || sw_ok;
  assign done_acc  = pkt_done && bank_com[rd_bank];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign bank_wr[i]     = wr_acc    && (wr_bank == 1'(i));
    assign bank_commit[i] = do_commit && (wr_bank == 1'(i));
    assign bank_rel[i]    = done_acc  && (rd_bank == 1'(i));
    assign com_next[i]    = (bank_com[i] || bank_commit[i]) && !bank_rel[i];

    inep_bank_state #(.CNT_W(CNT_W)) st_i (
      .clk       (clk),
      .rst       (rst),
      .wr_acc_i  (bank_wr[i]),
      .commit_i  (bank_commit[i]),
      .release_i (bank_rel[i]),
      .cnt_o     (bank_cnt[i]),
      .com_o     (bank_com[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bank  <= 1'b0;
      rd_bank  <= 1'b0;
      rd_ptr   <= '0;
      auto_arm <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      if (do_commit) wr_bank <= bank_flip(wr_bank);
      if (done_acc) begin
        rd_bank <= bank_flip(rd_bank);
        rd_ptr  <= '0;
      end else if (rd_stb && pkt_ready) begin
        rd_ptr <= rd_ptr + IDX_W'(1);
      end
      if (do_commit)   auto_arm <= fill_hit;
      else if (wr_acc) auto_arm <= 1'b0;
      dma_req <= dma_en && !(&com_next);
    end
  end

  inep_buf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk   (clk),
    .we    (wr_acc),
    .waddr ({wr_bank, cur_cnt[IDX_W-1:0]}),
    .wdata (wr_data),
    .raddr ({rd_bank, rd_ptr}),
    .rdata (rd_data)
  );

  assign pkt_ready = bank_com[rd_bank];
  assign pkt_len   = bank_cnt[rd_bank];
endmodule

// File: rtl/inep_dbuf_chk.sv
module inep_dbuf_chk #(
  parameter int unsigned BANK_BYTES = 64,
  parameter int unsigned CNT_W      = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 dma_en,
  input logic                 dma_req,
  input logic                 pkt_ready,
  input logic                 pkt_done,
  input logic [CNT_W-1:0]     pkt_len,
  input logic                 rd_bank,
  input logic [1:0][CNT_W-1:0] bank_cnt,
  input logic [1:0]           bank_com
);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    (bank_cnt[0] <= CNT_W'(BANK_BYTES)) && (bank_cnt[1] <= CNT_W'(BANK_BYTES)));

  assert_open_bank_not_full_R2: assert property (@(posedge clk) disable iff (rst)
    (!bank_com[0] |-> bank_cnt[0] < CNT_W'(BANK_BYTES)) and
    (!bank_com[1] |-> bank_cnt[1] < CNT_W'(BANK_BYTES)));

  assert_both_held_no_req_R6: assert property (@(posedge clk) disable iff (rst)
    (&bank_com) |-> !dma_req);

  assert_en_low_drops_req_R7: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> !dma_req);

  assert_len_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_ready && !pkt_done) |=> (pkt_ready && $stable(pkt_len)));

  assert_done_advances_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_ready && pkt_done) |=> (rd_bank != $past(rd_bank)));

  assert_held_banks_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    ((&bank_com) && !pkt_done) |=> $stable(bank_cnt));

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dma_req && !pkt_ready && pkt_len == '0));
endmodule

bind inep_dbuf_fifo inep_dbuf_chk #(.BANK_BYTES(BANK_BYTES), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .dma_en    (dma_en),
  .dma_req   (dma_req),
  .pkt_ready (pkt_ready),
  .pkt_done  (pkt_done),
  .pkt_len   (pkt_len),
  .rd_bank   (rd_bank),
  .bank_cnt  (bank_cnt),
  .bank_com  (bank_com)
);

// File: tb/inep_dbuf_fifo_tb.sv
`timescale 1ns/1ps
module inep_dbuf_fifo_tb_top;
  localparam int DW = 8;
  localparam int BB = 64;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dma_en = 0, wr_stb = 0, pkt_commit = 0, rd_stb = 0, pkt_done = 0;
  logic [DW-1:0] wr_data = '0;
  logic dma_req, pkt_ready;
  logic [CW-1:0] pkt_len;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  inep_dbuf_fifo #(.DATA_W(DW), .BANK_BYTES(BB)) dut_i (
    .clk(clk), .rst(rst), .dma_en(dma_en), .dma_req(dma_req),
    .wr_stb(wr_stb), .wr_data(wr_data), .pkt_commit(pkt_commit),
    .pkt_ready(pkt_ready), .pkt_len(pkt_len), .rd_stb(rd_stb),
    .rd_data(rd_data), .pkt_done(pkt_done)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // Packet-queue model
  logic [7:0] mq [2][64];
  int mlen [2];
  int head = 0, npk = 0;
  logic [7:0] part [64];
  int plen = 0;
  bit auto_arm = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic model_reset();
    head = 0; npk = 0; plen = 0; auto_arm = 0;
  endtask

  task automatic model_edge();
    int onpk;
    bit wacc, full, creq, dacc;
    onpk = npk;
    dacc = pkt_done && onpk > 0;
    wacc = wr_stb && onpk < 2;
    if (wacc) begin
      part[plen] = wr_data; plen++; auto_arm = 0;
    end
    full = wacc && plen == BB;
    creq = pkt_commit && onpk < 2 && !(plen == 0 && !wacc && auto_arm);
    if (full || creq) begin
      int slot;
      slot = (head + onpk) % 2;
      for (int k = 0; k < plen; k++) mq[slot][k] = part[k];
      mlen[slot] = plen;
      plen = 0;
      auto_arm = full;
      npk++;
    end
    if (dacc) begin
      head = (head + 1) % 2;
      npk--;
    end
  endtask

  // One clock: inputs are already driven; update model; check at negedge.
  task automatic tick();
    bit en_s;
    @(posedge clk);
    en_s = dma_en;
    if (rst) model_reset(); else model_edge();
    @(negedge clk);
    if (!rst) begin
      chk(dma_req == (en_s && npk < 2), "R6 dma_req", dma_req, en_s && npk < 2);
      chk(pkt_ready == (npk > 0), "R8 pkt_ready", pkt_ready, npk > 0);
      if (npk > 0) chk(pkt_len == mlen[head], "R8 pkt_len", pkt_len, mlen[head]);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_stb = 1; wr_data = d; tick(); wr_stb = 0;
  endtask

  task automatic write_n(input int n, input int base);
    for (int k = 0; k < n; k++) write_byte(8'((base + k * 7) & 8'hff));
  endtask

  task automatic commit();
    pkt_commit = 1; tick(); pkt_commit = 0;
  endtask

  // Drain presented packet; checks length and data (R1, R11).
  task automatic drain(input int exp_len);
    int len;
    chk(pkt_ready == 1'b1, "R8 ready before drain", pkt_ready, 1);
    chk(pkt_len == exp_len, "R3 R2 drained length", pkt_len, exp_len);
    len = pkt_len;
    for (int k = 0; k < len; k++) begin
      logic [7:0] e;
      e = mq[head][k];
      rd_stb = 1; tick();
      chk(rd_data == e, "R1 R11 rd_data", rd_data, e);
    end
    rd_stb = 0;
    pkt_done = 1; tick(); pkt_done = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    chk(dma_req == 0, "R10 dma_req after reset", dma_req, 0);
    chk(pkt_ready == 0, "R10 pkt_ready after reset", pkt_ready, 0);
    chk(pkt_len == 0, "R10 pkt_len after reset", pkt_len, 0);

    // R4: zero-length packet straight after reset
    commit();
    chk(pkt_ready && pkt_len == 0, "R4 zero-length commit", pkt_len, 0);
    drain(0);

    // R6: enabling raises request
    dma_en = 1; tick();
    chk(dma_req == 1, "R6 request with free bank", dma_req, 1);

    // 150-byte message: 64 auto, 64 auto, 22 software
    write_n(64, 3);
    chk(pkt_ready && pkt_len == 64, "R2 auto commit at 64", pkt_len, 64);
    write_n(64, 90);
    chk(dma_req == 0, "R6 both banks held", dma_req, 0);
    write_n(5, 200);                       // R9: ignored writes
    commit();                              // R5: ignored commit, both held
    chk(npk == 2, "R5 no extra packet when held", npk, 2);
    drain(64);                             // R9: data intact
    write_n(22, 17);
    chk(pkt_len == 64, "R3 partial not yet committed", pkt_len, 64);
    commit();
    drain(64);
    drain(22);                             // R3
    chk(pkt_ready == 0, "R8 queue empty after 150", pkt_ready, 0);

    // R5: exact 64 followed by stray commit
    write_n(64, 55);
    commit();
    drain(64);
    chk(pkt_ready == 0, "R5 stray commit after auto ignored", pkt_ready, 0);

    // R7: clearing enable withdraws request
    dma_en = 0; tick();
    chk(dma_req == 0, "R7 request withdrawn", dma_req, 0);
    dma_en = 1; tick();

    // Random mix
    for (int it = 0; it < 4000; it++) begin
      int r;
      r = $urandom % 20;
      if (r < 12) write_byte(8'($urandom));
      else if (r == 12) commit();
      else if (r < 16 && npk > 0) drain(mlen[head]);
      else if (r == 16) begin dma_en = ~dma_en; tick(); end
      else tick();
    end
    while (npk > 0) drain(mlen[head]);

    // R10: reset mid-traffic
    write_n(10, 1);
    rst = 1; tick(); rst = 0; tick();
    chk(pkt_ready == 0 && pkt_len == 0, "R10 reset clears banks", pkt_len, 0);
    report();
  end
endmodule